// File: doc/BRIEF.md
# Rename Register Occupancy Tracker

This block keeps the count of physical registers held in each of up to four rename register files of an out-of-order core. Every architectural destination register belongs to one owning file and costs a fixed number of physical registers; both facts come from a small per-register configuration table that is loaded from parameters while reset is asserted. File 0 is an aggregate file: every allocation or release is charged to it as well as to the owning file. A register whose owner is 0 is charged to file 0 alone.

Rename logic presents the destinations of the next instruction on a query port and gets back, in the same cycle, a bitmask with one bit per file that says the file has no room for them. Two allocation lanes and two release lanes then adjust the counters by cost. The block applies the rules under which a write holds no physical register: a write that produces zero, a move removed at rename, and a narrow write that merges into a wider register without clearing its upper part. For two writes of one instruction to the same register, it also reports which lane the rename map should keep.

Top module: `rename_occupancy_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, every counter in `used_cnt` becomes 0 and the configuration tables are loaded; allocation and release inputs have no effect in that cycle.
- R2: A counted allocation on a lane adds the register's cost to file 0 and, when the owner index is nonzero, also to the owning file, visible on `used_cnt` after the next clock edge. Tables: owner is 2 bits per register at bits [2r+1:2r], cost 2 bits per register at the same position. Default owners: registers 0-7 file 1, 8-11 file 2, 12-13 file 3, 14-15 file 0 only; default cost 2 for registers 8-11 and 1 for all others.
- R3: A counted release subtracts the cost from the same files as the allocation of that register would have added to.
- R4: A write flagged as zero-producing (`*_zero`) or as eliminated (`*_elim`) neither adds nor subtracts anything.
- R5: A write to a register marked in the partial table (bit r; default registers 6 and 7) is not counted unless `*_clr_upper` is 1; with the flag set it is counted like any other write.
- R6: The query sums, per file, the cost of every valid query lane (file 0 plus the owner). Bit f of `stall_mask` is 1 exactly when that sum is nonzero and used(f) plus the sum exceeds size(f). With no valid query lane the mask is 0. Sizes are 6 bits per file at bits [6f+5:6f]; defaults 20, 8, 3, 0 for files 0 to 3.
- R7: A per-file demand larger than the file's size is reduced to the size before the comparison.
- R8: A file with size 0 is unbounded and never sets its stall bit.
- R9: Allocations and releases in the same cycle are all applied; each counter stops at 0 and at 63 (all ones in 6 bits) instead of wrapping.
- R10: `al_keep[l]` is 1 for each valid, non-eliminated lane unless another such lane writes the same register with a longer latency, or with an equal latency from a higher lane number. Keep selection does not change counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| qry_valid | input | 2 | Valid bit per query lane |
| qry_reg | input | 8 | Destination register per query lane, lane l at [4l+3:4l] |
| al_valid | input | 2 | Valid bit per allocation lane |
| al_reg | input | 8 | Register per allocation lane |
| al_zero | input | 2 | Allocation write produces zero |
| al_elim | input | 2 | Allocation write removed at rename |
| al_clr_upper | input | 2 | Allocation write clears the upper part of the wider register |
| al_lat | input | 8 | Write latency per allocation lane |
| fr_valid | input | 2 | Valid bit per release lane |
| fr_reg | input | 8 | Register per release lane |
| fr_zero | input | 2 | Released write produced zero |
| fr_elim | input | 2 | Released write was removed at rename |
| fr_clr_upper | input | 2 | Released write cleared the upper part |
| stall_mask | output | 4 | Per-file no-room bit for the current query |
| al_keep | output | 2 | Lane kept in the rename map |
| used_cnt | output | 24 | Per-file physical registers in use, file f at [6f+5:6f] |

## Verification
A wrong owner, cost or partial-table entry, or a wrong skip rule, shows on `used_cnt` one clock edge after the allocation or release that touched it, as a count off by the cost in one or two files. A counter that has drifted is seen in the same cycle on `stall_mask` for any query that brings the file near its size, and a bad clamp or unbounded-file test shows only when a query asks for more than a file holds or targets a file of size 0, which the directed cases force. Saturation faults stay hidden until a counter is driven to 0 or 63, so dedicated runs push file counts past both ends.

// File: rtl/rot_pkg.sv
package rot_pkg;
    // Largest number of rename files the tracker supports.
    localparam int ROT_MAX_FILES = 4;

    // A write holds a physical register only if it is not a zero write,
    // not eliminated, and not a merging partial write.
    function automatic logic write_consumes(input logic is_zero, input logic is_elim,
                                            input logic is_partial, input logic clr_upper);
        return !is_zero && !is_elim && !(is_partial && !clr_upper);
    endfunction
endpackage

// File: rtl/rot_cfg_table.sv
// Per-register owner, cost and partial-write tables.
// Loaded from parameters while rst_n is low and held afterwards.
// Assumes NUM_ARCH is a power of two so every register code indexes an entry.
// Ports 0..Q_PORTS-1 are query lookups; the rest also look up the partial bit.
module rot_cfg_table #(
    parameter int NUM_ARCH = 16,
    parameter int ARCH_W   = 4,
    parameter int FIDX_W   = 2,
    parameter int COST_W   = 2,
    parameter int Q_PORTS  = 2,
    parameter int PORTS    = 6,
    parameter logic [NUM_ARCH*FIDX_W-1:0] OWNER_TAB   = '0,
    parameter logic [NUM_ARCH*COST_W-1:0] COST_TAB    = '0,
    parameter logic [NUM_ARCH-1:0]        PARTIAL_TAB = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PORTS*ARCH_W-1:0]     lk_reg,
    output logic [PORTS*FIDX_W-1:0]     lk_owner,
    output logic [PORTS*COST_W-1:0]     lk_cost,
    output logic [PORTS-Q_PORTS-1:0]    lk_partial
);
    logic [FIDX_W-1:0] owner_q [NUM_ARCH];
    logic [COST_W-1:0] cost_q  [NUM_ARCH];
    logic [NUM_ARCH-1:0] partial_q;

    // Load the tables during reset; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_ARCH; r++) begin
                owner_q[r] <= OWNER_TAB[r*FIDX_W +: FIDX_W];
                cost_q[r]  <= COST_TAB[r*COST_W +: COST_W];
            end
            partial_q <= PARTIAL_TAB;
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_lookup
        assign lk_owner[p*FIDX_W +: FIDX_W] = owner_q[lk_reg[p*ARCH_W +: ARCH_W]];
        assign lk_cost[p*COST_W +: COST_W]  = cost_q[lk_reg[p*ARCH_W +: ARCH_W]];
        if (p >= Q_PORTS) begin : g_part
            assign lk_partial[p-Q_PORTS] = partial_q[lk_reg[p*ARCH_W +: ARCH_W]];
        end
    end
endmodule

// File: rtl/rot_demand.sv
// Sums lane costs per file: file 0 takes every live lane, file f>0 takes
// the live lanes it owns. Assumes SUM_W holds N times the largest cost.
module rot_demand #(
    parameter int N         = 2,
    parameter int NUM_FILES = 4,
    parameter int FIDX_W    = 2,
    parameter int COST_W    = 2,
    parameter int SUM_W     = 4
) (
    input  logic [N-1:0]               live,
    input  logic [N*FIDX_W-1:0]        owner,
    input  logic [N*COST_W-1:0]        cost,
    output logic [NUM_FILES*SUM_W-1:0] need
);
    // Accumulate per-file demand over all lanes.
    always_comb begin
        need = '0;
        for (int f = 0; f < NUM_FILES; f++) begin
            for (int l = 0; l < N; l++) begin
                if (live[l] && (f == 0 || int'(owner[l*FIDX_W +: FIDX_W]) == f)) begin
                    need[f*SUM_W +: SUM_W] = need[f*SUM_W +: SUM_W]
                                           + SUM_W'(cost[l*COST_W +: COST_W]);
                end
            end
        end
    end
endmodule

// File: rtl/rot_counter.sv
// One saturating occupancy counter per file. Each cycle applies the sum
// of allocations and the sum of releases together; the result is held
// between 0 and the all-ones value of CNT_W bits.
module rot_counter #(
    parameter int NUM_FILES = 4,
    parameter int CNT_W     = 6,
    parameter int SUM_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_FILES*SUM_W-1:0]  add,
    input  logic [NUM_FILES*SUM_W-1:0]  sub,
    output logic [NUM_FILES*CNT_W-1:0]  used
);
    localparam int EXT_W = CNT_W + SUM_W + 1;
    localparam logic [EXT_W-1:0] CNT_MAX = {{(SUM_W+1){1'b0}}, {CNT_W{1'b1}}};

    for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] cnt_d;
        logic [EXT_W-1:0] grown;
        logic [EXT_W-1:0] diff;

        // Net update with clamping at both ends.
        always_comb begin
            grown = EXT_W'(cnt_q) + EXT_W'(add[f*SUM_W +: SUM_W]);
            diff  = grown - EXT_W'(sub[f*SUM_W +: SUM_W]);
            if (grown < EXT_W'(sub[f*SUM_W +: SUM_W]))
                cnt_d = '0;
            else if (diff > CNT_MAX)
                cnt_d = {CNT_W{1'b1}};
            else
                cnt_d = diff[CNT_W-1:0];
        end

        // Register the count; reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign used[f*CNT_W +: CNT_W] = cnt_q;
    end
endmodule

// File: rtl/rot_stall.sv
// Per-file room test for a query. Demand above the file size is clamped
// to the size; a size of zero means the file is unbounded.
module rot_stall #(
    parameter int NUM_FILES = 4,
    parameter int CNT_W     = 6,
    parameter int SUM_W     = 4,
    parameter logic [NUM_FILES*CNT_W-1:0] FILE_SIZE = '0
) (
    input  logic [NUM_FILES*CNT_W-1:0] used,
    input  logic [NUM_FILES*SUM_W-1:0] need,
    output logic [NUM_FILES-1:0]       stall_mask
);
    localparam int EXT_W = CNT_W + SUM_W + 1;

    for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
        localparam logic [EXT_W-1:0] SIZE_X = EXT_W'(FILE_SIZE[f*CNT_W +: CNT_W]);
        logic [EXT_W-1:0] need_x;
        logic [EXT_W-1:0] need_eff;

        // Clamp demand and compare against the remaining room.
        always_comb begin
            need_x   = EXT_W'(need[f*SUM_W +: SUM_W]);
            need_eff = (need_x > SIZE_X) ? SIZE_X : need_x;
            stall_mask[f] = (SIZE_X != '0) && (need_x != '0)
                         && ((EXT_W'(used[f*CNT_W +: CNT_W]) + need_eff) > SIZE_X);
        end
    end
endmodule

// File: rtl/rename_occupancy_tracker.sv
// Top of the rename occupancy tracker. Looks up owner and cost for query,
// allocation and release lanes, filters writes that hold no physical
// register, keeps per-file counters and answers the query with a stall
// mask. Assumes NUM_ARCH is a power of two and NUM_FILES <= 4.
module rename_occupancy_tracker
    import rot_pkg::*;
#(
    parameter int NUM_FILES = 4,
    parameter int NUM_ARCH  = 16,
    parameter int COST_W    = 2,
    parameter int CNT_W     = 6,
    parameter int LANES     = 2,
    parameter int DISP_N    = 2,
    parameter int LAT_W     = 4,
    parameter logic [NUM_ARCH*$clog2(NUM_FILES)-1:0] OWNER_TAB = 32'h0FAA_5555,
    parameter logic [NUM_ARCH*COST_W-1:0]            COST_TAB  = 32'h55AA_5555,
    parameter logic [NUM_ARCH-1:0]                   PARTIAL_TAB = 16'h00C0,
    parameter logic [NUM_FILES*CNT_W-1:0]            FILE_SIZE = {6'd0, 6'd3, 6'd8, 6'd20}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DISP_N-1:0]           qry_valid,
    input  logic [DISP_N*$clog2(NUM_ARCH)-1:0] qry_reg,
    input  logic [LANES-1:0]            al_valid,
    input  logic [LANES*$clog2(NUM_ARCH)-1:0]  al_reg,
    input  logic [LANES-1:0]            al_zero,
    input  logic [LANES-1:0]            al_elim,
    input  logic [LANES-1:0]            al_clr_upper,
    input  logic [LANES*LAT_W-1:0]      al_lat,
    input  logic [LANES-1:0]            fr_valid,
    input  logic [LANES*$clog2(NUM_ARCH)-1:0]  fr_reg,
    input  logic [LANES-1:0]            fr_zero,
    input  logic [LANES-1:0]            fr_elim,
    input  logic [LANES-1:0]            fr_clr_upper,
    output logic [NUM_FILES-1:0]        stall_mask,
    output logic [LANES-1:0]            al_keep,
    output logic [NUM_FILES*CNT_W-1:0]  used_cnt
);
    localparam int ARCH_W  = $clog2(NUM_ARCH);
    localparam int FIDX_W  = $clog2(NUM_FILES);
    localparam int MAX_N   = (LANES > DISP_N) ? LANES : DISP_N;
    localparam int SUM_W   = COST_W + $clog2(MAX_N + 1);
    localparam int PORTS   = DISP_N + 2 * LANES;
    localparam int AL_BASE = DISP_N;
    localparam int FR_BASE = DISP_N + LANES;

    logic [PORTS*ARCH_W-1:0]     lk_reg;
    logic [PORTS*FIDX_W-1:0]     lk_owner;
    logic [PORTS*COST_W-1:0]     lk_cost;
    logic [2*LANES-1:0]          lk_partial;
    logic [LANES-1:0]            al_live;
    logic [LANES-1:0]            fr_live;
    logic [LANES-1:0]            al_cand;
    logic [NUM_FILES*SUM_W-1:0]  q_need;
    logic [NUM_FILES*SUM_W-1:0]  al_add;
    logic [NUM_FILES*SUM_W-1:0]  fr_sub;

    assign lk_reg = {fr_reg, al_reg, qry_reg};

    rot_cfg_table #(
        .NUM_ARCH(NUM_ARCH), .ARCH_W(ARCH_W), .FIDX_W(FIDX_W), .COST_W(COST_W),
        .Q_PORTS(DISP_N), .PORTS(PORTS),
        .OWNER_TAB(OWNER_TAB), .COST_TAB(COST_TAB), .PARTIAL_TAB(PARTIAL_TAB)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .lk_reg(lk_reg),
        .lk_owner(lk_owner), .lk_cost(lk_cost), .lk_partial(lk_partial)
    );

    // Decide per lane whether the write holds a physical register.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            al_live[l] = al_valid[l] && write_consumes(al_zero[l], al_elim[l],
                                                       lk_partial[l], al_clr_upper[l]);
            fr_live[l] = fr_valid[l] && write_consumes(fr_zero[l], fr_elim[l],
                                                       lk_partial[LANES+l], fr_clr_upper[l]);
        end
    end

    rot_demand #(.N(DISP_N), .NUM_FILES(NUM_FILES), .FIDX_W(FIDX_W),
                 .COST_W(COST_W), .SUM_W(SUM_W)) u_qry_need (
        .live(qry_valid),
        .owner(lk_owner[0 +: DISP_N*FIDX_W]),
        .cost(lk_cost[0 +: DISP_N*COST_W]),
        .need(q_need)
    );

    rot_demand #(.N(LANES), .NUM_FILES(NUM_FILES), .FIDX_W(FIDX_W),
                 .COST_W(COST_W), .SUM_W(SUM_W)) u_al_need (
        .live(al_live),
        .owner(lk_owner[AL_BASE*FIDX_W +: LANES*FIDX_W]),
        .cost(lk_cost[AL_BASE*COST_W +: LANES*COST_W]),
        .need(al_add)
    );

    rot_demand #(.N(LANES), .NUM_FILES(NUM_FILES), .FIDX_W(FIDX_W),
                 .COST_W(COST_W), .SUM_W(SUM_W)) u_fr_need (
        .live(fr_live),
        .owner(lk_owner[FR_BASE*FIDX_W +: LANES*FIDX_W]),
        .cost(lk_cost[FR_BASE*COST_W +: LANES*COST_W]),
        .need(fr_sub)
    );

    rot_counter #(.NUM_FILES(NUM_FILES), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .add(al_add), .sub(fr_sub), .used(used_cnt)
    );

    rot_stall #(.NUM_FILES(NUM_FILES), .CNT_W(CNT_W), .SUM_W(SUM_W),
                .FILE_SIZE(FILE_SIZE)) u_stall (
        .used(used_cnt), .need(q_need), .stall_mask(stall_mask)
    );

    // Pick the surviving lane among same-register writes: longer latency
    // wins, a tie goes to the higher lane.
    always_comb begin
        al_cand = al_valid & ~al_elim;
        for (int i = 0; i < LANES; i++) begin
            al_keep[i] = al_cand[i];
            for (int j = 0; j < LANES; j++) begin
                if (j != i && al_cand[j]
                    && al_reg[j*ARCH_W +: ARCH_W] == al_reg[i*ARCH_W +: ARCH_W]
                    && (al_lat[j*LAT_W +: LAT_W] > al_lat[i*LAT_W +: LAT_W]
                        || (al_lat[j*LAT_W +: LAT_W] == al_lat[i*LAT_W +: LAT_W] && j > i)))
                    al_keep[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rot_checker.sv
// Property checker for the occupancy tracker, attached by bind.
module rot_checker #(
    parameter int NUM_FILES = 4,
    parameter int CNT_W     = 6,
    parameter int LANES     = 2,
    parameter int DISP_N    = 2,
    parameter logic [NUM_FILES*CNT_W-1:0] FILE_SIZE = '0
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [DISP_N-1:0]          qry_valid,
    input logic [LANES-1:0]           al_valid,
    input logic [LANES-1:0]           al_zero,
    input logic [LANES-1:0]           al_elim,
    input logic [LANES-1:0]           al_keep,
    input logic [LANES-1:0]           fr_valid,
    input logic [NUM_FILES-1:0]       stall_mask,
    input logic [NUM_FILES*CNT_W-1:0] used_cnt
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> used_cnt == '0); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (al_valid == '0 && fr_valid == '0) |=> used_cnt == $past(used_cnt)); // R2

    AST_SKIPPED_WRITES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid == '0 && (al_valid & ~(al_zero | al_elim)) == '0) |=> $stable(used_cnt)); // R4

    AST_NO_QUERY_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid == '0 |-> stall_mask == '0); // R6

    AST_KEEP_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (al_keep & ~(al_valid & ~al_elim)) == '0); // R10

    for (genvar f = 0; f < NUM_FILES; f++) begin : g_unb
        if (FILE_SIZE[f*CNT_W +: CNT_W] == '0) begin : g_zero
            AST_UNBOUNDED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                !stall_mask[f]); // R8
        end
    end
endmodule

bind rename_occupancy_tracker rot_checker #(
    .NUM_FILES(NUM_FILES), .CNT_W(CNT_W), .LANES(LANES), .DISP_N(DISP_N),
    .FILE_SIZE(FILE_SIZE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .qry_valid(qry_valid), .al_valid(al_valid),
    .al_zero(al_zero), .al_elim(al_elim), .al_keep(al_keep), .fr_valid(fr_valid),
    .stall_mask(stall_mask), .used_cnt(used_cnt)
);

// File: tb/rename_occupancy_tracker_tb.sv
module rename_occupancy_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 4;
    localparam int AW = 4;
    localparam int CW = 6;
    localparam int LN = 2;
    localparam int DN = 2;
    localparam int LW = 4;
    localparam int CMAX = 63;

    logic clk = 1'b0;
    logic rst_n;
    logic [DN-1:0]    qry_valid;
    logic [DN*AW-1:0] qry_reg;
    logic [LN-1:0]    al_valid, al_zero, al_elim, al_clr_upper;
    logic [LN*AW-1:0] al_reg;
    logic [LN*LW-1:0] al_lat;
    logic [LN-1:0]    fr_valid, fr_zero, fr_elim, fr_clr_upper;
    logic [LN*AW-1:0] fr_reg;
    logic [NF-1:0]    stall_mask;
    logic [LN-1:0]    al_keep;
    logic [NF*CW-1:0] used_cnt;

    int m_used [NF];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_occupancy_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .qry_valid(qry_valid), .qry_reg(qry_reg),
        .al_valid(al_valid), .al_reg(al_reg), .al_zero(al_zero), .al_elim(al_elim),
        .al_clr_upper(al_clr_upper), .al_lat(al_lat), .fr_valid(fr_valid),
        .fr_reg(fr_reg), .fr_zero(fr_zero), .fr_elim(fr_elim),
        .fr_clr_upper(fr_clr_upper), .stall_mask(stall_mask), .al_keep(al_keep),
        .used_cnt(used_cnt)
    );

    // Configuration as stated in the requirements.
    function automatic int b_owner(int r);
        if (r < 8)  return 1;
        if (r < 12) return 2;
        if (r < 14) return 3;
        return 0;
    endfunction
    function automatic int b_cost(int r);
        return (r >= 8 && r < 12) ? 2 : 1;
    endfunction
    function automatic bit b_partial(int r);
        return (r == 6 || r == 7);
    endfunction
    function automatic int b_size(int f);
        case (f)
            0: return 20;
            1: return 8;
            2: return 3;
            default: return 0;
        endcase
    endfunction
    function automatic bit b_counts(bit v, bit z, bit e, bit p, bit c);
        return v && !z && !e && !(p && !c);
    endfunction

    task automatic check_int(string tag, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
        end
    endtask

    task automatic clear_in();
        qry_valid = '0; qry_reg = '0;
        al_valid = '0; al_reg = '0; al_zero = '0; al_elim = '0; al_clr_upper = '0; al_lat = '0;
        fr_valid = '0; fr_reg = '0; fr_zero = '0; fr_elim = '0; fr_clr_upper = '0;
    endtask

    task automatic set_al(int l, int r, bit z, bit e, bit c, int lat);
        al_valid[l] = 1'b1; al_reg[l*AW +: AW] = AW'(r); al_zero[l] = z;
        al_elim[l] = e; al_clr_upper[l] = c; al_lat[l*LW +: LW] = LW'(lat);
    endtask

    task automatic set_fr(int l, int r, bit z, bit e, bit c);
        fr_valid[l] = 1'b1; fr_reg[l*AW +: AW] = AW'(r); fr_zero[l] = z;
        fr_elim[l] = e; fr_clr_upper[l] = c;
    endtask

    task automatic set_q(int l, int r);
        qry_valid[l] = 1'b1; qry_reg[l*AW +: AW] = AW'(r);
    endtask

    // Check combinational outputs, clock once, then check the counters.
    task automatic run_cycle(string tag);
        int add [NF];
        int sub [NF];
        int need [NF];
        int exp_mask, exp_keep, eff, t;
        #1;
        for (int f = 0; f < NF; f++) begin add[f] = 0; sub[f] = 0; need[f] = 0; end
        for (int l = 0; l < DN; l++) begin
            if (qry_valid[l]) begin
                int r = int'(qry_reg[l*AW +: AW]);
                need[0] += b_cost(r);
                if (b_owner(r) != 0) need[b_owner(r)] += b_cost(r);
            end
        end
        exp_mask = 0;
        for (int f = 0; f < NF; f++) begin
            eff = (need[f] > b_size(f)) ? b_size(f) : need[f];
            if (b_size(f) != 0 && need[f] != 0 && m_used[f] + eff > b_size(f))
                exp_mask |= (1 << f);
        end
        check_int(tag, "stall_mask", int'(stall_mask), exp_mask);
        exp_keep = 0;
        for (int i = 0; i < LN; i++) begin
            bit keep = al_valid[i] && !al_elim[i];
            for (int j = 0; j < LN; j++) begin
                if (j != i && al_valid[j] && !al_elim[j]
                    && al_reg[j*AW +: AW] == al_reg[i*AW +: AW]) begin
                    int lj = int'(al_lat[j*LW +: LW]);
                    int li = int'(al_lat[i*LW +: LW]);
                    if (lj > li || (lj == li && j > i)) keep = 0;
                end
            end
            if (keep) exp_keep |= (1 << i);
        end
        check_int(tag, "al_keep", int'(al_keep), exp_keep);
        for (int l = 0; l < LN; l++) begin
            int ra = int'(al_reg[l*AW +: AW]);
            int rf = int'(fr_reg[l*AW +: AW]);
            if (b_counts(al_valid[l], al_zero[l], al_elim[l], b_partial(ra), al_clr_upper[l])) begin
                add[0] += b_cost(ra);
                if (b_owner(ra) != 0) add[b_owner(ra)] += b_cost(ra);
            end
            if (b_counts(fr_valid[l], fr_zero[l], fr_elim[l], b_partial(rf), fr_clr_upper[l])) begin
                sub[0] += b_cost(rf);
                if (b_owner(rf) != 0) sub[b_owner(rf)] += b_cost(rf);
            end
        end
        @(posedge clk);
        for (int f = 0; f < NF; f++) begin
            t = m_used[f] + add[f] - sub[f];
            if (t < 0) t = 0;
            if (t > CMAX) t = CMAX;
            m_used[f] = t;
        end
        @(negedge clk);
        for (int f = 0; f < NF; f++)
            check_int(tag, $sformatf("used_cnt[%0d]", f), int'(used_cnt[f*CW +: CW]), m_used[f]);
    endtask

    task automatic check_reset(string tag);
        for (int f = 0; f < NF; f++) begin
            m_used[f] = 0;
            check_int(tag, $sformatf("used_cnt[%0d] in reset", f), int'(used_cnt[f*CW +: CW]), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog all requirements got 0 exp 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd20240601));
        rst_n = 1'b0;
        clear_in();
        repeat (3) @(negedge clk);
        check_reset("R1");
        rst_n = 1'b1;
        check_int("R6", "stall_mask idle", int'(stall_mask), 0);

        // R2: mixed owners and costs, owner-0 register
        clear_in(); set_al(0, 0, 0, 0, 0, 1); set_al(1, 8, 0, 0, 0, 1); set_q(0, 0); run_cycle("R2");
        clear_in(); set_al(0, 14, 0, 0, 0, 1); run_cycle("R2 owner0");
        // R4: zero and eliminated writes
        clear_in(); set_al(0, 1, 1, 0, 0, 1); set_al(1, 2, 0, 1, 0, 1); run_cycle("R4 alloc");
        // R5: partial merge vs clearing partial write
        clear_in(); set_al(0, 6, 0, 0, 0, 2); run_cycle("R5 merge");
        clear_in(); set_al(0, 7, 0, 0, 1, 2); run_cycle("R5 clear");
        // R9 and R3: same-cycle allocate and release
        clear_in(); set_fr(0, 0, 0, 0, 0); set_al(0, 1, 0, 0, 0, 1); run_cycle("R9 both");
        clear_in(); set_fr(0, 1, 1, 0, 0); set_fr(1, 3, 0, 1, 0); run_cycle("R4 free");
        clear_in(); set_fr(0, 7, 0, 0, 0); run_cycle("R5 free merge");
        // R6: fill file 1, then query
        for (int k = 0; k < 3; k++) begin
            clear_in(); set_al(0, 2, 0, 0, 0, 1); set_al(1, 3, 0, 0, 0, 1); run_cycle("R2 fill");
        end
        clear_in(); set_q(0, 3); run_cycle("R6 file1 full");
        clear_in(); set_q(0, 8); set_q(1, 12); run_cycle("R6 other files");
        // R7: release file 2 then ask for more than its size
        clear_in(); set_fr(0, 8, 0, 0, 0); run_cycle("R3");
        clear_in(); set_q(0, 8); set_q(1, 9); run_cycle("R7 clamp");
        clear_in(); set_al(0, 10, 0, 0, 0, 1); run_cycle("R2");
        clear_in(); set_q(0, 9); run_cycle("R6 file2");
        // R8: unbounded file 3
        for (int k = 0; k < 5; k++) begin
            clear_in(); set_al(0, 12, 0, 0, 0, 1); set_al(1, 13, 0, 0, 0, 1);
            set_q(0, 12); set_q(1, 13); run_cycle("R8 unbounded");
        end
        // R10: duplicate destination keep rule
        clear_in(); set_al(0, 4, 0, 0, 0, 5); set_al(1, 4, 0, 0, 0, 3); run_cycle("R10 longer lane0");
        clear_in(); set_al(0, 4, 0, 0, 0, 3); set_al(1, 4, 0, 0, 0, 3); run_cycle("R10 tie");
        clear_in(); set_al(0, 4, 0, 0, 0, 2); set_al(1, 5, 0, 0, 0, 9); run_cycle("R10 distinct");
        clear_in(); set_al(0, 4, 0, 0, 0, 2); set_al(1, 4, 0, 1, 0, 9); run_cycle("R10 elim");
        // R9: saturation at top and bottom
        for (int k = 0; k < 20; k++) begin
            clear_in(); set_al(0, 8, 0, 0, 0, 1); set_al(1, 9, 0, 0, 0, 1); run_cycle("R9 max");
        end
        for (int k = 0; k < 35; k++) begin
            clear_in(); set_fr(0, 8, 0, 0, 0); set_fr(1, 0, 0, 0, 1); run_cycle("R9 zero");
        end
        // Random mix
        for (int k = 0; k < 1500; k++) begin
            clear_in();
            for (int l = 0; l < LN; l++) begin
                if ($urandom_range(0, 1) == 1)
                    set_al(l, int'($urandom_range(0, 15)), $urandom_range(0, 7) == 0,
                           $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1,
                           int'($urandom_range(0, 15)));
                if ($urandom_range(0, 1) == 1)
                    set_fr(l, int'($urandom_range(0, 15)), $urandom_range(0, 7) == 0,
                           $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1);
            end
            for (int l = 0; l < DN; l++)
                if ($urandom_range(0, 2) != 0) set_q(l, int'($urandom_range(0, 15)));
            run_cycle("R2 R3 R6 random");
        end
        // R1: reset mid-run overrides a pending allocation
        clear_in(); set_al(0, 0, 0, 0, 0, 1); set_al(1, 8, 0, 0, 0, 1);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check_reset("R1 mid-run");
        rst_n = 1'b1;
        clear_in(); set_al(0, 9, 0, 0, 0, 1); run_cycle("R1 after reset");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule